// File: doc/BRIEF.md
# Fractional-Prescaled UART Baud Generator

This block turns a fixed 62.5 MHz input clock into the two timing strobes a UART needs. The first is a sample tick at the oversampling rate, which the receiver and transmitter use to sample and shift. The second is a bit tick at the serial bit rate. Three programmable stages run in cascade. A fractional prescaler divides the clock by a value with one-eighth resolution. A 16-bit integer divisor divides the prescaler pulses into sample ticks. An oversampling counter divides the sample ticks into bit ticks. The resulting bit rate is the input clock divided by (oversampling ratio × prescaler value × divisor).

The fractional prescaler is a phase accumulator. Each clock it adds eight. Once the sum reaches the programmed value in eighths, it emits one pulse and subtracts that value. The average division is therefore exact, and each pulse lands on the first clock at which the ideal time has been reached. Software sets the three fields and the prescaler enable through a small register-write port. Every write restarts all stages from zero, so no shortened or stretched period reaches the serial logic.

Top module: `frac_baud_gen`

## Requirements
- R1: A write (cfg_we high at a clock edge) updates one field chosen by cfg_sel. Select 0 loads the divisor from cfg_wdata[15:0]. Select 1 loads the prescaler in eighths from cfg_wdata[8:0] and the prescaler enable from cfg_wdata[15]. Select 2 loads the oversampling field from cfg_wdata[3:0]. Select 3 loads no field.
- R2: Take clock 1 as the first edge after the last configuration write. With effective ratio R, prescaler P in eighths and divisor D, the n-th sample tick is on clock ceil(n·D·P/8) and the first bit tick is on clock ceil(R·D·P/8).
- R3: Oversampling field values 4 to 16 give that ratio. Field values 0 to 3 give a ratio of 16.
- R4: Prescaler field values 8 to 511 divide by value/8 (1.000 to 63.875). Field values 0 to 7 behave as 8 (divide by 1.000).
- R5: When the prescaler enable is clear, the prescaler divides by 1 whatever its field holds.
- R6: A divisor field of 0 divides by 65536 when ZERO_DIV_MAX is 1. When ZERO_DIV_MAX is 0, it stops all ticks.
- R7: Any write clears all three stages. Both strobes are low in the clock after the write, and counting restarts from zero whatever partial period was in progress.
- R8: Every bit tick coincides with a sample tick, and bit_tick is never high on two consecutive clocks.
- R9: During reset both strobes are low. The reset configuration is ratio 16, prescaler disabled and divisor 1, so the first bit tick after reset release is on clock 16.
- R10: Over a window of W clocks after a write, the count of sample ticks is floor(8W/(D·P)) and the count of bit ticks is floor(8W/(R·D·P)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 62.5 MHz input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Field select for the write |
| cfg_wdata | input | 16 | Write data |
| sample_tick | output | 1 | One-clock strobe at the oversampling rate |
| bit_tick | output | 1 | One-clock strobe at the bit rate |

## Verification
The assertions check four things on every cycle. Each bit tick coincides with a sample tick and is never two clocks wide. Both strobes fall quiet in the clock after a write. The accumulator and the oversampling count stay below their effective limits. Only the bench scenarios can show the arithmetic: the exact clock on which the first bit tick appears for each ratio, fractional prescaler and divisor, the strobe counts over long windows, and the clamping of out-of-range fields. The same scenarios cover the restart of a partial period, the effect of the enable bit and the zero-divisor case.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int OS_W  = 4;
  localparam int PRE_W = 9;
  localparam int DIV_W = 16;
  localparam int SEL_W = 2;
  localparam int DAT_W = 16;
  localparam int ACC_W = PRE_W + 1;
  localparam int RAT_W = OS_W + 1;
  localparam int LIM_W = DIV_W + 1;
  localparam int EN_BIT = DAT_W - 1;
  localparam logic [PRE_W-1:0] ONE_EIGHTHS = PRE_W'(8);

  typedef enum logic [SEL_W-1:0] {
    SEL_DIV   = 2'd0,
    SEL_PRE   = 2'd1,
    SEL_RATIO = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [OS_W-1:0]  ratio_f;
    logic [PRE_W-1:0] pre_f;
    logic             pre_en;
    logic [DIV_W-1:0] div_f;
  } baud_cfg_t;

  // Oversampling field to ratio; small codes fold to 16.
  function automatic logic [RAT_W-1:0] eff_ratio(input logic [OS_W-1:0] f);
    if (f < OS_W'(4)) return RAT_W'(16);
    return RAT_W'(f);
  endfunction

  // Prescaler field (eighths) to effective eighths; disabled or sub-unity is 8.
  function automatic logic [PRE_W-1:0] eff_eighths(input logic [PRE_W-1:0] f,
                                                   input logic en);
    if (!en) return ONE_EIGHTHS;
    if (f < ONE_EIGHTHS) return ONE_EIGHTHS;
    return f;
  endfunction

  // Divisor field to terminal count; zero means max or "never".
  function automatic logic [LIM_W-1:0] div_limit(input logic [DIV_W-1:0] d,
                                                 input bit zero_max);
    if (d != '0) return LIM_W'(d);
    if (zero_max) return LIM_W'(1) << DIV_W;
    return '0;
  endfunction
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [DAT_W-1:0] wdata,
  output baud_cfg_t        cfg
);
  baud_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.ratio_f <= '0;
      cfg_q.pre_f   <= '0;
      cfg_q.pre_en  <= 1'b0;
      cfg_q.div_f   <= DIV_W'(1);
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_DIV:   cfg_q.div_f   <= wdata[DIV_W-1:0];
        SEL_PRE: begin
          cfg_q.pre_f  <= wdata[PRE_W-1:0];
          cfg_q.pre_en <= wdata[EN_BIT];
        end
        SEL_RATIO: cfg_q.ratio_f <= wdata[OS_W-1:0];
        default:   ;
      endcase
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PRE_W-1:0] eighths,
  output logic             fire,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] acc_q, acc_d, sum;

  always_comb begin
    sum   = acc_q + ACC_W'(8);
    fire  = !clr && (sum >= ACC_W'(eighths));
    if (clr)       acc_d = '0;
    else if (fire) acc_d = sum - ACC_W'(eighths);
    else           acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/baud_mod_counter.sv
module baud_mod_counter #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         fire,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;

  assign fire = !clr && step && (limit != '0) && (cnt_q == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (fire)  cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + W'(1);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter bit ZERO_DIV_MAX = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [DAT_W-1:0] cfg_wdata,
  output logic             sample_tick,
  output logic             bit_tick
);
  baud_cfg_t        cfg;
  logic [PRE_W-1:0] eighths_w;
  logic [RAT_W-1:0] ratio_w;
  logic [LIM_W-1:0] div_lim_w;
  logic             pre_pulse, smp_pulse, bit_pulse;
  logic [ACC_W-1:0] pre_acc;
  logic [LIM_W-1:0] div_cnt;
  logic [RAT_W-1:0] os_cnt;
  logic             sample_q, bit_q;

  baud_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  assign eighths_w = eff_eighths(cfg.pre_f, cfg.pre_en);
  assign ratio_w   = eff_ratio(cfg.ratio_f);
  assign div_lim_w = div_limit(cfg.div_f, ZERO_DIV_MAX);

  baud_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clr(cfg_we), .eighths(eighths_w),
    .fire(pre_pulse), .acc(pre_acc)
  );

  baud_mod_counter #(.W(LIM_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(cfg_we), .step(pre_pulse),
    .limit(div_lim_w), .fire(smp_pulse), .cnt(div_cnt)
  );

  baud_mod_counter #(.W(RAT_W)) u_os (
    .clk(clk), .rst_n(rst_n), .clr(cfg_we), .step(smp_pulse),
    .limit(ratio_w), .fire(bit_pulse), .cnt(os_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      sample_q <= smp_pulse;
      bit_q    <= bit_pulse;
    end
  end

  assign sample_tick = sample_q;
  assign bit_tick    = bit_q;
endmodule

// File: rtl/frac_baud_gen_checker.sv
module frac_baud_gen_checker
  import baud_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             sample_tick,
  input logic             bit_tick,
  input logic [ACC_W-1:0] acc,
  input logic [PRE_W-1:0] eighths,
  input logic [RAT_W-1:0] os_cnt,
  input logic [RAT_W-1:0] ratio
);
  a_r8_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  a_r8_bit_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  a_r7_quiet_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!sample_tick && !bit_tick));

  a_r2_acc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    acc < ACC_W'(eighths));

  a_r3_os_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    os_cnt < ratio);
endmodule

bind frac_baud_gen frac_baud_gen_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
  .sample_tick(sample_tick), .bit_tick(bit_tick),
  .acc(pre_acc), .eighths(eighths_w), .os_cnt(os_cnt), .ratio(ratio_w)
);

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        sample_tick, bit_tick;

  int checks = 0;
  int errors = 0;
  int bad_r8 = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  frac_baud_gen i_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  typedef struct packed {
    logic [3:0]  os;
    logic [8:0]  pre;
    logic        en;
    logic [15:0] dv;
    logic [31:0] win;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  9'd8,   1'b1, 16'd1, 32'd40},     // R2 fastest rate
    '{4'd7,  9'd31,  1'b1, 16'd5, 32'd1200},   // R4 fractional 3.875
    '{4'd14, 9'd10,  1'b1, 16'd31, 32'd2000},  // R4 fractional 1.250
    '{4'd0,  9'd8,   1'b0, 16'd3, 32'd500},    // R3 code 0 is 16
    '{4'd5,  9'd3,   1'b1, 16'd2, 32'd100},    // R4 sub-unity clamps to 8
    '{4'd4,  9'd31,  1'b0, 16'd1, 32'd40},     // R5 enable clear bypasses
    '{4'd15, 9'd511, 1'b1, 16'd1, 32'd3000},   // R4 largest prescaler
    '{4'd3,  9'd8,   1'b1, 16'd1, 32'd40},     // R3 code 3 is 16
    '{4'd4,  9'd8,   1'b1, 16'd0, 32'd65540}   // R6 zero divisor is 65536
  };

  function automatic longint ratio_of(int f);
    return (f <= 3) ? 16 : f;
  endfunction
  function automatic longint pre_of(int f, int en);
    if (en == 0) return 8;
    return (f < 8) ? 8 : f;
  endfunction
  function automatic longint div_of(int f);
    return (f == 0) ? 65536 : f;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_all(int os, int pre, int en, int dv);
    wr(2'd2, 16'(os));
    wr(2'd1, {en[0], 6'd0, pre[8:0]});
    wr(2'd0, 16'(dv));
  endtask

  task automatic measure(input int w, output int first_b, output int n_s, output int n_b);
    logic prev_b;
    first_b = 0; n_s = 0; n_b = 0; prev_b = 1'b0;
    for (int k = 1; k <= w; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (sample_tick) n_s++;
      if (bit_tick) begin
        n_b++;
        if (first_b == 0) first_b = k;
        if (!sample_tick || prev_b) bad_r8++;
      end
      prev_b = bit_tick;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int fb, ns, nb;
    longint r, p, d, w, first_e;

    // R9 reset state and defaults
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 sample_tick in reset", sample_tick, 0);
    check("R9 bit_tick in reset", bit_tick, 0);
    rst_n = 1'b1;
    measure(40, fb, ns, nb);
    check("R9 first bit after reset", fb, 16);
    check("R9 samples after reset", ns, 40);

    // Table walk: R1 R2 R10 plus the clamps tagged per vector
    for (int i = 0; i < NV; i++) begin
      cfg_all(int'(VECS[i].os), int'(VECS[i].pre), int'(VECS[i].en), int'(VECS[i].dv));
      measure(int'(VECS[i].win), fb, ns, nb);
      r = ratio_of(int'(VECS[i].os));
      p = pre_of(int'(VECS[i].pre), int'(VECS[i].en));
      d = div_of(int'(VECS[i].dv));
      w = longint'(VECS[i].win);
      first_e = (r * d * p + 7) / 8;
      if (first_e > w) first_e = 0;
      check($sformatf("R2 first bit tick vec %0d", i), fb, first_e);
      check($sformatf("R10 sample count vec %0d", i), ns, (8 * w) / (d * p));
      check($sformatf("R10 bit count vec %0d", i), nb, (8 * w) / (r * d * p));
    end

    // R7 quiet clock right after a write when ticks run every clock
    cfg_all(4, 8, 1, 1);
    measure(10, fb, ns, nb);
    wr(2'd0, 16'd1);
    check("R7 sample_tick low after write", sample_tick, 0);
    measure(40, fb, ns, nb);
    check("R7 first bit after rewrite", fb, 4);

    // R7 partial period discarded
    cfg_all(0, 8, 1, 10);
    measure(70, fb, ns, nb);
    check("R7 no bit before restart", nb, 0);
    wr(2'd0, 16'd10);
    measure(200, fb, ns, nb);
    check("R7 first bit counted from restart", fb, 160);

    // R1 select 3 loads nothing but restarts
    wr(2'd3, 16'hFFFF);
    measure(200, fb, ns, nb);
    check("R1 select 3 leaves config", fb, 160);

    check("R8 bit ticks single and on sample ticks", bad_r8, 0);
    summary();
  end
endmodule